// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns one parallel character at a time into an asynchronous serial frame. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bit times. A single holding register sits in front of the shifter. The block raises `ready` while that register is empty. A new character written during a frame waits in the register and goes out as soon as the current stop period ends.

Bit timing comes from one of two sources. The first is a baud enable that pulses at sixteen times the bit rate, so a bit lasts 16 enable pulses. The second is an external strobe at the bit rate, selected when the clock-select code is all ones. Flow control is optional. When it is enabled, an active-low clear-to-send input is synchronised and then checked at the moment a character would start. The serial line stays at the marking level for as long as that input is high.

Top module: `sertx_cts`

## Requirements
- R1: After reset, and whenever no character is in flight, `txd` is 1. After reset `ready` is 1.
- R2: A frame begins with one low start bit, followed by 5 + `char_len` data bits sent least significant bit first. Bits of `wr_data` above that length are not sent.
- R3: When `par_en` is 1, a parity bit follows the data. With `par_odd` = 0 the data bits plus the parity bit hold an even number of ones. With `par_odd` = 1 they hold an odd number.
- R4: In 16x mode every bit lasts 16 `tick16` pulses. The stop period is set by `stop_sel`: 00 gives 16 pulses, 01 gives 24, and 10 or 11 give 32.
- R5: When `clk_sel` is 4'b1111, each `ext_clk1x` strobe times one bit and `tick16` is ignored. In this mode `stop_sel` 00 and 01 both give one stop bit, and 10 or 11 give two.
- R6: A write (`wr_en` high for one cycle) is accepted only while `ready` is 1, and `ready` is 0 in the following cycle. A write made while `ready` is 0 is ignored and produces no frame.
- R7: If a character is waiting, and clear-to-send permits, when a stop period ends, its start bit begins right away with no idle gap.
- R8: When `cts_en` is 0, `cts_n` has no effect on transmission.
- R9: When `cts_en` is 1, a character starts only while `cts_n` is low after a two-flop synchronizer. While `cts_n` is high, `txd` stays 1 and the character stays in the holding register.
- R10: A change of `cts_n` after a start bit has begun does not alter that frame, which completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| ext_clk1x | input | 1 | One-cycle strobe at the bit rate, used in 1x mode |
| clk_sel | input | 4 | Clock source code; all ones selects 1x mode |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Asynchronous active-low clear-to-send |
| stop_sel | input | 2 | Stop length code |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Adds a parity bit |
| par_odd | input | 1 | Selects odd parity when 1 |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| ready | output | 1 | Holding register empty |
| txd | output | 1 | Serial output, high when idle |

## Verification
The hardest case to reach is a clear-to-send change in the middle of a frame while a second character already sits in the holding register. The first frame has to finish untouched, and the second has to stay blocked. The bench reaches this by lowering `cts_n` and writing one character. It waits for the start bit on `txd`, then raises `cts_n` and writes a second character. It then watches the line stay marking after the first frame ends, before it releases `cts_n`. Stop lengths are measured exactly by queueing back-to-back characters and timing the gap between consecutive start edges.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  localparam logic [1:0] STOP_ONE  = 2'b00;
  localparam logic [1:0] STOP_HALF = 2'b01;

  // Length of the stop period in timing units.
  function automatic logic [5:0] stop_units(input logic [1:0] sel, input logic x1);
    if (x1) begin
      stop_units = (sel == STOP_ONE || sel == STOP_HALF) ? 6'd1 : 6'd2;
    end else begin
      case (sel)
        STOP_ONE:  stop_units = 6'd16;
        STOP_HALF: stop_units = 6'd24;
        default:   stop_units = 6'd32;
      endcase
    end
  endfunction

endpackage

// File: rtl/sertx_ctssync.sv
module sertx_ctssync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_n_in,
  output logic cts_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '1;
    else     pipe_q <= {pipe_q[STAGES-2:0], cts_n_in};
  end

  assign cts_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/sertx_bittimer.sv
module sertx_bittimer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          unit,
  input  logic          restart,
  input  logic [CW-1:0] target,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign done    = unit && !restart && (cnt_inc == target);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (done)      cnt_q <= '0;
    else if (unit)      cnt_q <= cnt_inc;
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < target);
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
  import sertx_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          unit,
  input  logic          bit_done,
  input  logic          x1_mode,
  input  logic          cts_en,
  input  logic          cts_s,
  input  logic [1:0]    stop_sel,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          ready,
  output logic          txd,
  output logic          restart,
  output logic [CW-1:0] target
);
  localparam logic [3:0] MIN_BITS = 4'd5;

  tx_state_e     state_q;
  logic [DW-1:0] hold_q, sh_q;
  logic          full_q, par_q, pen_q, txd_q;
  logic [1:0]    len_q, stop_q;
  logic [3:0]    bit_idx_q;
  logic [3:0]    nbits;
  logic [DW-1:0] len_mask;
  logic          cts_ok, slot, launch;

  assign nbits    = MIN_BITS + {2'b00, len_q};
  assign len_mask = {DW{1'b1}} >> (2'd3 - char_len);
  assign cts_ok   = !cts_en || !cts_s;
  assign slot     = (state_q == ST_IDLE) ? unit : (state_q == ST_STOP && bit_done);
  assign launch   = full_q && cts_ok && slot;

  assign restart  = (state_q == ST_IDLE);
  assign target   = (state_q == ST_STOP) ? stop_units(stop_q, x1_mode)
                                         : (x1_mode ? 6'd1 : 6'd16);
  assign ready    = !full_q;
  assign txd      = txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      hold_q    <= '0;
      sh_q      <= '0;
      full_q    <= 1'b0;
      par_q     <= 1'b0;
      pen_q     <= 1'b0;
      len_q     <= '0;
      stop_q    <= '0;
      bit_idx_q <= '0;
      txd_q     <= 1'b1;
    end else if (launch) begin
      full_q    <= 1'b0;
      sh_q      <= hold_q;
      par_q     <= (^(hold_q & len_mask)) ^ par_odd;
      pen_q     <= par_en;
      len_q     <= char_len;
      stop_q    <= stop_sel;
      bit_idx_q <= '0;
      state_q   <= ST_START;
      txd_q     <= 1'b0;
    end else begin
      if (wr_en && !full_q) begin
        full_q <= 1'b1;
        hold_q <= wr_data;
      end
      if (bit_done) begin
        case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            txd_q   <= sh_q[0];
          end
          ST_DATA: begin
            if (bit_idx_q == nbits - 4'd1) begin
              state_q <= pen_q ? ST_PAR : ST_STOP;
              txd_q   <= pen_q ? par_q : 1'b1;
            end else begin
              bit_idx_q <= bit_idx_q + 4'd1;
              sh_q      <= sh_q >> 1;
              txd_q     <= sh_q[1];
            end
          end
          ST_PAR: begin
            state_q <= ST_STOP;
            txd_q   <= 1'b1;
          end
          ST_STOP: state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> txd_q);
  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ready) |=> !ready);
  // R6
  ignored_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ready) |=> (hold_q == $past(hold_q)));
  // R9
  cts_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(txd_q) && state_q == ST_START && $past(cts_en)) |-> !$past(cts_s));
  // R2
  bit_index_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA) |-> (bit_idx_q < nbits));
endmodule

// File: rtl/sertx_cts.sv
module sertx_cts #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CW          = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          ext_clk1x,
  input  logic [3:0]    clk_sel,
  input  logic          cts_en,
  input  logic          cts_n,
  input  logic [1:0]    stop_sel,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          ready,
  output logic          txd
);
  logic          x1_mode, unit, cts_s, restart, bit_done;
  logic [CW-1:0] target;

  assign x1_mode = &clk_sel;
  assign unit    = x1_mode ? ext_clk1x : tick16;

  sertx_ctssync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cts_n_in(cts_n), .cts_n_sync(cts_s)
  );

  sertx_bittimer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .unit(unit), .restart(restart),
    .target(target), .done(bit_done)
  );

  sertx_fsm #(.DW(DW), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .unit(unit), .bit_done(bit_done),
    .x1_mode(x1_mode), .cts_en(cts_en), .cts_s(cts_s),
    .stop_sel(stop_sel), .char_len(char_len), .par_en(par_en),
    .par_odd(par_odd), .wr_en(wr_en), .wr_data(wr_data),
    .ready(ready), .txd(txd), .restart(restart), .target(target)
  );
endmodule

// File: tb/sertx_cts_tb.sv
module sertx_cts_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0, ext_clk1x = 1'b0;
  logic [3:0] clk_sel = 4'h0;
  logic       cts_en = 1'b0, cts_n = 1'b1;
  logic [1:0] stop_sel = 2'b00, char_len = 2'b11;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ready, txd;

  sertx_cts u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .ext_clk1x(ext_clk1x),
    .clk_sel(clk_sel), .cts_en(cts_en), .cts_n(cts_n), .stop_sel(stop_sel),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
    .wr_en(wr_en), .wr_data(wr_data), .ready(ready), .txd(txd)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  int div16 = 0, div1 = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    div16 <= (div16 == 1) ? 0 : div16 + 1;
    div1  <= (div1 == 4) ? 0 : div1 + 1;
  end
  always @(negedge clk) begin
    tick16    <= (div16 == 1);
    ext_clk1x <= (div1 == 4);
  end

  typedef struct {
    logic [7:0] d;
    int nb;
    bit pe;
    bit po;
    int bitc;
    int stopc;
    bit b2b;
    string sreq;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  int pushed = 0, frames_done = 0, last_end = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit b2b);
    item_t it;
    bit x1;
    x1 = (clk_sel == 4'hF);
    while (ready !== 1'b1) @(negedge clk);
    it.d = d; it.nb = 5 + int'(char_len); it.pe = par_en; it.po = par_odd;
    it.bitc = x1 ? 5 : 32;
    if (x1) it.stopc = (stop_sel[1]) ? 10 : 5;
    else it.stopc = (stop_sel == 2'b00) ? 32 : (stop_sel == 2'b01) ? 48 : 64;
    it.sreq = x1 ? "R5" : "R4";
    it.b2b = b2b;
    sb_q.push_back(it);
    pushed++;
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(ready == 1'b0, "R6 ready drop", ready, 0);
  endtask

  task automatic drain();
    while (frames_done != pushed) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic hold_high(input int n, input string req);
    bit bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (txd !== 1'b1) bad = 1;
    end
    check(!bad, req, 0, 1);
  endtask

  // Monitor: decodes frames and compares them against the scoreboard.
  initial begin
    item_t it;
    logic [7:0] got;
    logic gp, exp_p;
    int t0, frame;
    bit stop_bad;
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        t0 = cyc;
        if (sb_q.size() == 0) begin
          check(0, "R6 unexpected frame", 1, 0);
          while (txd !== 1'b1) @(negedge clk);
        end else begin
          it = sb_q.pop_front();
          frame = it.bitc * (1 + it.nb + int'(it.pe)) + it.stopc;
          if (it.b2b) check(t0 == last_end, {"R7 ", it.sreq, " start spacing"}, t0, last_end);
          repeat (it.bitc / 2) @(negedge clk);
          check(txd == 1'b0, "R2 start bit", txd, 0);
          got = 8'h00;
          for (int i = 0; i < it.nb; i++) begin
            repeat (it.bitc) @(negedge clk);
            got[i] = txd;
          end
          check(got == (it.d & (8'hFF >> (8 - it.nb))), "R2 data", got,
                it.d & (8'hFF >> (8 - it.nb)));
          if (it.pe) begin
            repeat (it.bitc) @(negedge clk);
            gp = txd;
            exp_p = (^(it.d & (8'hFF >> (8 - it.nb)))) ^ it.po;
            check(gp == exp_p, "R3 parity", gp, exp_p);
          end
          repeat (it.bitc) @(negedge clk);
          stop_bad = (txd !== 1'b1);
          while (cyc < t0 + frame - 1) begin
            @(negedge clk);
            if (txd !== 1'b1) stop_bad = 1;
          end
          check(!stop_bad, {it.sreq, " stop level"}, 0, 1);
          last_end = t0 + frame;
          frames_done++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R1 idle txd", txd, 1);
    check(ready == 1'b1, "R1 ready after reset", ready, 1);

    // R2 R4: 8 bits, no parity, one stop bit, back to back
    char_len = 2'b11; stop_sel = 2'b00;
    send(8'hA5, 0); send(8'h3C, 1); drain();
    // R3 R4: 7 bits even parity, 1.5 stop
    char_len = 2'b10; par_en = 1; par_odd = 0; stop_sel = 2'b01;
    send(8'hD3, 0); send(8'h41, 1); drain();
    // R3 R4: 5 bits odd parity, two stop bits, high bits dropped
    char_len = 2'b00; par_odd = 1; stop_sel = 2'b10;
    send(8'hFF, 0); send(8'hE4, 1); drain();
    // R4: code 11 also gives two stop bits, 6 bits
    char_len = 2'b01; par_en = 0; stop_sel = 2'b11;
    send(8'h15, 0); send(8'h2A, 1); drain();
    // R5: 1x mode, 1.5 requested is one stop bit, then two
    clk_sel = 4'hF; char_len = 2'b11; stop_sel = 2'b01;
    send(8'h96, 0); send(8'h69, 1); drain();
    stop_sel = 2'b10; par_en = 1; par_odd = 0;
    send(8'h0F, 0); send(8'hF1, 1); drain();
    clk_sel = 4'h0; par_en = 0; stop_sel = 2'b00;

    // R6: write while full is ignored
    send(8'h11, 0); send(8'h22, 1);
    check(ready == 1'b0, "R6 holding full", ready, 0);
    wr_en = 1'b1; wr_data = 8'h33;
    @(negedge clk);
    wr_en = 1'b0;
    drain();
    hold_high(400, "R6 no frame from ignored write");
    check(sb_q.size() == 0, "R6 scoreboard empty", sb_q.size(), 0);

    // R9: CTS high blocks the start
    cts_en = 1; cts_n = 1;
    send(8'h5A, 0);
    hold_high(400, "R9 marking while CTS high");
    check(ready == 1'b0, "R9 character held", ready, 0);
    cts_n = 0; drain();

    // R10: CTS rises mid-frame; frame completes, next one waits
    send(8'hC3, 0);
    while (txd !== 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    cts_n = 1;
    send(8'h7E, 0);
    while (frames_done != pushed - 1) @(negedge clk);
    hold_high(300, "R10 next character blocked");
    check(ready == 1'b0, "R9 second character held", ready, 0);
    cts_n = 0; drain();

    // R8: gating disabled, CTS high has no effect
    cts_en = 0; cts_n = 1;
    send(8'h81, 0); send(8'h18, 1); drain();
    check(txd == 1'b1, "R1 idle after frames", txd, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule